// File: doc/BRIEF.md
# Packed Lane Arithmetic and Mask Unit

This block is a 64-bit packed-data arithmetic unit. It treats each 64-bit operand as a row of independent lanes: eight bytes, four 16-bit halves, two 32-bit words, or one 64-bit value. Per lane it can add the two operands, either wrapping modulo the lane range or clamping at the unsigned maximum. It can also compare the operands for equality and return a lane that is all ones or all zeros.

It also performs bitwise AND, OR, and an inverted-first-operand AND. With these, a mask from an equality compare can merge two pictures pixel by pixel. A typical use is colour-key compositing: compare a foreground against a key colour to get a mask, then build `(~mask & fg) | (mask & bg)` in three more operations.

Each operation is launched with a one-cycle `start` pulse. The operands and controls are sampled on the same clock edge. The result and its valid strobe appear in registers one cycle later, and the result then holds until the next launch.

Top module: `simd_alu`

## Requirements
- R1: While `rstN` is low, and after it is released, `result` reads zero and `resultValid` is low until the first launch.
- R2: When `start` is sampled high on a rising edge, `resultValid` is high for exactly the following cycle. With `start` low, `resultValid` is low and `result` keeps its value.
- R3: `laneSel` selects the lane width: 2'b00 for 8-bit, 2'b01 for 16-bit, 2'b10 for 32-bit and 2'b11 for 64-bit. With opcode 3'b000 (add) and `satEn` low, each lane holds (a+b) mod 2^w, and no carry crosses a lane boundary. For example, bytes 100+200 give 44.
- R4: With opcode 3'b000 and `satEn` high at 8-, 16- or 32-bit width, a lane whose unsigned sum exceeds 2^w−1 holds 2^w−1 (0xFF for a byte). Other lanes hold the plain sum.
- R5: At 64-bit width the add always wraps modulo 2^64, whatever the value of `satEn`.
- R6: Opcode 3'b001 (compare-equal) sets every bit of a lane when the two operand lanes are equal, and clears the lane otherwise.
- R7: Opcode 3'b010 returns `opA & opB`, and opcode 3'b100 returns `opA | opB`, whatever the value of `laneSel`.
- R8: Opcode 3'b011 returns `~opA & opB`. With a compare mask in `opA`, this keeps the foreground where the mask is clear, so the chain compare, inverted-AND, AND, OR composites two images.
- R9: `satEn` has no effect on opcodes other than add.
- R10: Opcodes 3'b101, 3'b110 and 3'b111 produce an all-zero result and still raise `resultValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse; operands and controls sampled with it |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| laneSel | input | 2 | Lane width code (00=8, 01=16, 10=32, 11=64 bits) |
| opcode | input | 3 | Operation code |
| satEn | input | 1 | Unsigned saturation for add |
| result | output | 64 | Registered packed result |
| resultValid | output | 1 | High for the cycle after a launch |

## Verification
The bench's main target is the lane boundary. It uses sums that carry out of every byte, half and word. A design that let a carry leak into the next lane would corrupt the neighbouring lane's low bit, and one that cut carries inside a wide lane would give wrong 16- and 32-bit sums.

For saturation, it checks lanes that overflow next to lanes that do not. A wrong lane-end selection would then clamp the wrong lane or the whole word. It also checks the 64-bit lane with saturation requested, where a clamp would show up as all ones.

Compare masks are tried where one byte differs inside a wide lane; a per-byte compare would leave part of that lane set. A full colour-key composite checks that the inverted-AND takes its inversion from the correct operand.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int DATA_W = 64;
  localparam int BYTE_W = 8;
  localparam int NUM_BYTES = DATA_W / BYTE_W;

  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } lane_e;

  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_CMPEQ = 3'b001,
    OP_AND   = 3'b010,
    OP_ANDN  = 3'b011,
    OP_OR    = 3'b100
  } op_e;

  typedef struct packed {
    logic       load;
    logic [2:0] op;
    lane_e      lane;
    logic       sat;
  } dp_ctrl_t;

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int NB = DW / BYTE_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  lane_e         lane,
  input  logic          sat,
  output logic [DW-1:0] addOut,
  output logic [DW-1:0] eqOut
);

  logic [NB-1:0]     byteEq;
  logic [NB-1:0]     carryOut;
  logic [BYTE_W-1:0] byteSum [NB];

  // per-byte equality, one comparator per byte
  for (genvar g = 0; g < NB; g++) begin : g_eq
    assign byteEq[g] = (a[g*BYTE_W +: BYTE_W] == b[g*BYTE_W +: BYTE_W]);
  end

  // carry chain broken at every lane start
  always_comb begin
    int  span;
    logic c;
    span = (1 << lane) - 1;
    c = 1'b0;
    for (int i = 0; i < NB; i++) begin
      logic cin;
      cin = ((i & span) == 0) ? 1'b0 : c;
      {c, byteSum[i]} = {1'b0, a[i*BYTE_W +: BYTE_W]} + {1'b0, b[i*BYTE_W +: BYTE_W]}
                        + {{BYTE_W{1'b0}}, cin};
      carryOut[i] = c;
    end
  end

  // saturation and lane-wide equality broadcast
  always_comb begin
    int span;
    span = (1 << lane) - 1;
    addOut = '0;
    eqOut  = '0;
    for (int i = 0; i < NB; i++) begin
      logic clamp;
      logic laneEq;
      clamp = sat && (lane != LANE_64) && carryOut[i | span];
      addOut[i*BYTE_W +: BYTE_W] = clamp ? {BYTE_W{1'b1}} : byteSum[i];
      laneEq = 1'b1;
      for (int j = 0; j < NB; j++) begin
        if ((j & ~span) == (i & ~span)) laneEq = laneEq & byteEq[j];
      end
      eqOut[i*BYTE_W +: BYTE_W] = {BYTE_W{laneEq}};
    end
  end

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_ctrl_t      ctrl,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  output logic [DW-1:0] resultQ
);

  logic [DW-1:0] addOut;
  logic [DW-1:0] eqOut;
  logic [DW-1:0] nextRes;

  simd_lane_unit #(.DW(DW)) laneUnit_i (
    .a      (opA),
    .b      (opB),
    .lane   (ctrl.lane),
    .sat    (ctrl.sat),
    .addOut (addOut),
    .eqOut  (eqOut)
  );

  always_comb begin
    unique case (ctrl.op)
      OP_ADD:   nextRes = addOut;
      OP_CMPEQ: nextRes = eqOut;
      OP_AND:   nextRes = opA & opB;
      OP_ANDN:  nextRes = ~opA & opB;
      OP_OR:    nextRes = opA | opB;
      default:  nextRes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          resultQ <= '0;
    else if (ctrl.load) resultQ <= nextRes;
  end

endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] laneSel,
  input  logic [2:0] opcode,
  input  logic       satEn,
  output dp_ctrl_t   ctrl,
  output logic       validQ
);

  always_comb begin
    ctrl.load = start;
    ctrl.op   = opcode;
    ctrl.lane = lane_e'(laneSel);
    ctrl.sat  = satEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= start;
  end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [1:0]  laneSel,
  input  logic [2:0]  opcode,
  input  logic        satEn,
  output logic [63:0] result,
  output logic        resultValid
);

  dp_ctrl_t ctrl;

  simd_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .laneSel (laneSel),
    .opcode  (opcode),
    .satEn   (satEn),
    .ctrl    (ctrl),
    .validQ  (resultValid)
  );

  simd_datapath #(.DW(64)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .resultQ (result)
  );

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic [1:0]  laneSel,
  input logic [2:0]  opcode,
  input logic        satEn,
  input logic [63:0] result,
  input logic        resultValid
);

  // R1
  reset_state_chk: assert property (@(posedge clk) !rstN |-> (result == '0 && !resultValid));

  // R2
  valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resultValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !resultValid);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(result));

  // R5
  wide_add_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 3'b000 && laneSel == 2'b11) |=> result == $past(opA + opB));

  // R6
  cmp_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 3'b001 && opA == opB) |=> result == {64{1'b1}});

  // R7
  and_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 3'b010) |=> result == $past(opA & opB));

  // R7
  or_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 3'b100) |=> result == $past(opA | opB));

  // R8
  andn_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode == 3'b011) |=> result == $past(~opA & opB));

  // R10
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opcode > 3'b100) |=> result == '0);

endmodule

bind simd_alu simd_alu_chk chk_i (.*);

// File: tb/simd_alu_tb.sv
module simd_alu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [1:0]  laneSel = '0;
  logic [2:0]  opcode = '0;
  logic        satEn = 1'b0;
  logic [63:0] result;
  logic        resultValid;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [63:0] expResult = '0;
  logic        expValid = 1'b0;
  string       expTag = "R1";

  always #5 clk = ~clk;

  simd_alu dut_i (.*);

  function automatic logic [63:0] refModel(logic [63:0] a, logic [63:0] b,
                                           logic [1:0] sel, logic [2:0] op, logic sat);
    int w;
    logic [63:0] r;
    w = 8 << sel;
    r = '0;
    case (op)
      3'b000: begin
        for (int k = 0; k < 64 / w; k++) begin
          logic [64:0] x, y, s, lim;
          x = 65'((a >> (k * w)) & ((w == 64) ? ~64'd0 : ((64'd1 << w) - 1)));
          y = 65'((b >> (k * w)) & ((w == 64) ? ~64'd0 : ((64'd1 << w) - 1)));
          s = x + y;
          lim = (65'd1 << w) - 1;
          if (sat && w < 64 && s > lim) s = lim;
          s = s & lim;
          r = r | (s[63:0] << (k * w));
        end
      end
      3'b001: begin
        for (int k = 0; k < 64 / w; k++) begin
          logic [63:0] m;
          m = (w == 64) ? ~64'd0 : ((64'd1 << w) - 1);
          if (((a >> (k * w)) & m) == ((b >> (k * w)) & m)) r = r | (m << (k * w));
        end
      end
      3'b010: r = a & b;
      3'b011: r = ~a & b;
      3'b100: r = a | b;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic compareNow();
    tests++;
    if (result !== expResult || resultValid !== expValid) begin
      fails++;
      $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
               expTag, result, resultValid, expResult, expValid);
    end
  endtask

  task automatic step(bit st, logic [63:0] a, logic [63:0] b, logic [1:0] sel,
                      logic [2:0] op, logic sat, string tag);
    @(negedge clk);
    compareNow();
    start = st; opA = a; opB = b; laneSel = sel; opcode = op; satEn = sat;
    if (st) begin
      expResult = refModel(a, b, sel, op, sat);
      expValid  = 1'b1;
      expTag    = tag;
    end else begin
      expValid = 1'b0;
      expTag   = tag;
    end
  endtask

  task automatic checkVal(logic [63:0] got, logic [63:0] want, string tag);
    tests++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, want);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] fg, bg, mask, keep, fill, comp, want;
    // R1: outputs at reset
    #1;
    checkVal(result, 64'd0, "R1 reset result");
    checkVal({63'd0, resultValid}, 64'd0, "R1 reset valid");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, '0, '0, 2'b00, 3'b000, 0, "R1");
    step(0, '0, '0, 2'b00, 3'b000, 0, "R1");

    // R3: byte wrap, 100+200=44
    step(1, 64'h64646464_64646464, 64'hC8C8C8C8_C8C8C8C8, 2'b00, 3'b000, 0, "R3 byte wrap");
    step(0, '0, '0, 2'b00, 3'b000, 0, "R2 hold");
    checkVal(result, 64'h2C2C2C2C_2C2C2C2C, "R3 100+200=44");
    // R4: byte saturate to 255 next to non-overflowing lane
    step(1, 64'h64011164_64FF0064, 64'hC8FE0110_C8010010, 2'b00, 3'b000, 1, "R4 byte sat");
    // R3: carry must not leak across any lane width
    for (int s = 0; s < 4; s++) begin
      step(1, 64'hFFFFFFFF_FFFFFFFF, 64'h00000001_00010001, 2'(s), 3'b000, 0, "R3 lane carry");
      step(1, 64'hFF00FFFF_80007FFF, 64'h0100FF01_80000001, 2'(s), 3'b000, 1, "R4 lane sat");
    end
    // R5: 64-bit lane wraps despite saturation
    step(1, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_00000002, 2'b11, 3'b000, 1, "R5 wide wrap");
    step(0, '0, '0, 2'b11, 3'b000, 0, "R2 idle");
    checkVal(result, 64'd1, "R5 wide wrap value");
    // R6: compare with one byte differing inside wide lanes
    for (int s = 0; s < 4; s++)
      step(1, 64'h11223344_55667788, 64'h11223344_55667789, 2'(s), 3'b001, 0, "R6 cmpeq");
    step(1, 64'h15151515_15151515, 64'h15151515_15151515, 2'b10, 3'b001, 0, "R6 cmpeq all");
    // R7, R8, R9, R10
    step(1, 64'hF0F0_AAAA_1234_FFFF, 64'h0FF0_5555_FF00_0F0F, 2'b01, 3'b010, 1, "R7 and");
    step(1, 64'hF0F0_AAAA_1234_FFFF, 64'h0FF0_5555_FF00_0F0F, 2'b00, 3'b100, 1, "R7 or");
    step(1, 64'hF0F0_AAAA_1234_FFFF, 64'h0FF0_5555_FF00_0F0F, 2'b10, 3'b011, 0, "R8 andn");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 3'b011, 1, "R9 sat ignored");
    step(0, '0, '0, 2'b00, 3'b000, 0, "R9");
    checkVal(result, 64'd0, "R9 andn with sat high");
    for (int o = 5; o < 8; o++)
      step(1, 64'hDEADBEEF_CAFEF00D, 64'h12345678_9ABCDEF0, 2'b00, 3'(o), 1, "R10 reserved");
    step(0, '0, '0, 2'b00, 3'b000, 0, "R2 idle");
    step(0, '0, '0, 2'b00, 3'b000, 0, "R2 idle");

    // R8: colour-key composite
    fg = 64'h15_15_64_78_65_4C_15_15;
    bg = 64'hA1_A2_A3_A4_A5_A6_A7_A8;
    step(1, fg, 64'h15151515_15151515, 2'b00, 3'b001, 0, "R6 key mask");
    step(0, '0, '0, 2'b00, 3'b000, 0, "R2");
    mask = result;
    checkVal(mask, 64'hFF_FF_00_00_00_00_FF_FF, "R6 key mask value");
    step(1, mask, fg, 2'b00, 3'b011, 0, "R8 keep fg");
    step(0, '0, '0, 2'b00, 3'b000, 0, "R2");
    keep = result;
    step(1, mask, bg, 2'b00, 3'b010, 0, "R7 fill bg");
    step(0, '0, '0, 2'b00, 3'b000, 0, "R2");
    fill = result;
    step(1, keep, fill, 2'b00, 3'b100, 0, "R7 merge");
    step(0, '0, '0, 2'b00, 3'b000, 0, "R2");
    comp = result;
    want = '0;
    for (int i = 0; i < 8; i++)
      want[i*8 +: 8] = (fg[i*8 +: 8] == 8'h15) ? bg[i*8 +: 8] : fg[i*8 +: 8];
    checkVal(comp, want, "R8 composite");

    // random mix, compared every cycle (R3 R4 R6 R7)
    for (int n = 0; n < 400; n++) begin
      step(1'($urandom_range(0, 3) != 0), {$urandom, $urandom}, {$urandom, $urandom},
           2'($urandom), 3'($urandom_range(0, 7)), 1'($urandom), "R3 R4 R6 R7 random");
    end
    step(0, '0, '0, 2'b00, 3'b000, 0, "R2");
    @(negedge clk);
    compareNow();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule